// File: doc/BRIEF.md
# Per-pin selectable input filter

This block sits between already-synchronised pad inputs and the logic that consumes them, such as data readback and interrupt detection. Each of the pins either passes its input straight through or sends it through a filter. An enabled filter runs in one of two modes. Glitch mode samples on every system clock and rejects very short pulses. Debounce mode samples only on a slow tick and rejects bounces that are shorter than the tick period.

Software sets up the block through a write-only register bus. Each strobe register takes a pin mask, and every 1 bit in the mask acts on that pin. A single divider field is shared by all pins and sets the debounce tick. The slow clock is given to the block as a one-cycle enable, `slow_en`. A debounce tick occurs once every 2×(DIV+1) slow enables. Writing the divider restarts the tick count. The expected setup order is to select debounce, then program the divider, then enable the filter.

Top module: `pad_filter`

## Requirements
- R1: While a pin's filter is disabled, `filt_out` for that pin equals `pad_in` in the same cycle, with no register on the path.
- R2: Writing address 0 (enable strobe) turns the filter on for every pin whose data bit is 1. Pins whose data bit is 0 keep their previous enable state.
- R3: Writing address 1 (disable strobe) turns the filter off for every pin whose data bit is 1, and those pins go back to pass-through.
- R4: In glitch mode, the filtered value takes a new input level only after two consecutive system-clock samples of that level. A one-cycle pulse never reaches `filt_out`.
- R5: Writing address 3 selects debounce mode for the masked pins. In that mode the input is sampled only on ticks, and the output follows a new level only after two consecutive ticks see it.
- R6: Writing address 4 stores bits [DIVW-1:0] of the data as the divider and drops all higher bits. It also restarts the tick count, so the first tick arrives on the 2×(DIV+1)-th slow enable after the write.
- R7: Writing address 2 selects glitch mode for the masked pins. Disabling a filter leaves that pin's mode selection unchanged.
- R8: After reset, every filter is disabled, every pin is in glitch mode, and the divider is 0, which gives a tick every 2 slow enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 enable, 1 disable, 2 glitch select, 3 debounce select, 4 divider |
| wr_data | input | 32 | Write data: a pin mask, or the divider value |
| slow_en | input | 1 | One-cycle enable standing in for the slow clock |
| pad_in | input | 32 | Synchronised raw pin inputs |
| filt_out | output | 32 | Filtered or passed-through pin values |

## Verification
A wrong enable bit shows up at once: a disabled pin mirrors `pad_in` in the same cycle, while an enabled pin holds its level through a one-cycle pulse. A wrong mode bit shows up two system clocks after an input step, because a pin in glitch mode follows the step at that point and a pin in debounce mode does not. A wrong divider or a tick counter that was not restarted moves the output change away from exactly the 2×2×(DIV+1)-th slow enable. The debounce checks therefore sample one enable before that edge and again at it.

// File: rtl/pad_filter_pkg.sv
package pad_filter_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_FILT_ON  = 3'd0;
   localparam logic [ADDR_W-1:0] A_FILT_OFF = 3'd1;
   localparam logic [ADDR_W-1:0] A_SEL_GLT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_SEL_DBN  = 3'd3;
   localparam logic [ADDR_W-1:0] A_DIVIDER  = 3'd4;
endpackage

// File: rtl/pad_filter_regs.sv
module pad_filter_regs
   import pad_filter_pkg::*;
#(
   parameter int NPIN = 32,
   parameter int DIVW = 14,
   parameter int BUSW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUSW-1:0]   wr_data,
   output logic [NPIN-1:0]   en_o,
   output logic [NPIN-1:0]   dbn_o,
   output logic [DIVW-1:0]   div_o,
   output logic              div_wr_o
);
   logic [NPIN-1:0] mask;
   logic [NPIN-1:0] en_q, dbn_q;
   logic [DIVW-1:0] div_q;

   assign mask     = wr_data[NPIN-1:0];
   assign div_wr_o = wr_en && (wr_addr == A_DIVIDER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         dbn_q <= '0;
         div_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_FILT_ON:  en_q  <= en_q | mask;
            A_FILT_OFF: en_q  <= en_q & ~mask;
            A_SEL_GLT:  dbn_q <= dbn_q & ~mask;
            A_SEL_DBN:  dbn_q <= dbn_q | mask;
            A_DIVIDER:  div_q <= wr_data[DIVW-1:0];
            default: ;
         endcase
      end
   end

   assign en_o  = en_q;
   assign dbn_o = dbn_q;
   assign div_o = div_q;

   AST_DIV_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr_o |=> div_o == $past(wr_data[DIVW-1:0])); // R6
   AST_OFF_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_FILT_OFF) |=> $stable(dbn_o)); // R7
endmodule

// File: rtl/pad_filter_tick.sv
module pad_filter_tick #(
   parameter int DIVW = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_en,
   input  logic [DIVW-1:0] div_i,
   input  logic            div_wr_i,
   output logic            tick_o
);
   localparam int CNTW = DIVW + 1;
   logic [CNTW-1:0] cnt_q;
   logic [CNTW-1:0] limit;
   logic            at_end;

   assign limit  = {div_i, 1'b1};
   assign at_end = (cnt_q == limit);
   assign tick_o = slow_en && at_end && !div_wr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (div_wr_i)
         cnt_q <= '0;
      else if (slow_en)
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit); // R6
   AST_TICK_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> slow_en); // R5
endmodule

// File: rtl/pad_filter_lane.sv
module pad_filter_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic step,
   input  logic en,
   output logic dout
);
   logic smp_q, st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= 1'b0;
         st_q  <= 1'b0;
      end else if (step) begin
         smp_q <= din;
         if (din == smp_q) st_q <= din;
      end
   end

   assign dout = en ? st_q : din;

   AST_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != $past(st_q)) |-> ($past(smp_q) == st_q && $past(din) == st_q)); // R4
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(st_q)); // R5
endmodule

// File: rtl/pad_filter.sv
module pad_filter
   import pad_filter_pkg::*;
#(
   parameter int NPIN = 32,
   parameter int DIVW = 14,
   parameter int BUSW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUSW-1:0]   wr_data,
   input  logic              slow_en,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   filt_out
);
   generate
      if (NPIN < 1 || NPIN > BUSW) begin : g_bad_npin
         $error("NPIN must be between 1 and BUSW");
      end
      if (DIVW < 1 || DIVW >= BUSW) begin : g_bad_divw
         $error("DIVW must be between 1 and BUSW-1");
      end
   endgenerate

   logic [NPIN-1:0] en, dbn;
   logic [DIVW-1:0] div;
   logic            div_wr, tick;

   pad_filter_regs #(.NPIN(NPIN), .DIVW(DIVW), .BUSW(BUSW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .en_o(en), .dbn_o(dbn), .div_o(div), .div_wr_o(div_wr)
   );

   pad_filter_tick #(.DIVW(DIVW)) u_tick (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .div_i(div),
      .div_wr_i(div_wr), .tick_o(tick)
   );

   for (genvar i = 0; i < NPIN; i++) begin : g_lane
      logic step;
      assign step = dbn[i] ? tick : 1'b1;
      pad_filter_lane u_lane (
         .clk(clk), .rst_n(rst_n), .din(pad_in[i]), .step(step),
         .en(en[i]), .dout(filt_out[i])
      );
      AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(en[i]) && !en[i]) |-> filt_out[i] == pad_in[i]); // R1
   end
endmodule

// File: tb/pad_filter_bench.sv
module pad_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        slow_en = 1'b0;
   logic [31:0] pad_in = '0;
   logic [31:0] filt_out;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pad_filter u_pad_filter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .slow_en(slow_en), .pad_in(pad_in), .filt_out(filt_out)
   );

   // {input bit, expected output after the edge}, glitch mode
   localparam logic [1:0] GVEC [0:11] = '{2'b10, 2'b00, 2'b10, 2'b11, 2'b01, 2'b11,
                                          2'b01, 2'b00, 2'b10, 2'b11, 2'b11, 2'b01};

   task automatic chk(input string tag, input logic [31:0] exp);
      checks++;
      if (filt_out !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, filt_out, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic slow(input int n);
      for (int k = 0; k < n; k++) begin
         slow_en = 1'b1;
         @(negedge clk);
         slow_en = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);
      // R1 / R8: filters off after reset, pass-through
      pad_in = 32'hA5A5_0F0F; #1;
      chk("R1 R8 reset pass-through", 32'hA5A5_0F0F);
      pad_in = 32'h0; idle(3);
      // R2: enable lower half only, apply one-cycle pulse
      wr(3'd0, 32'h0000_FFFF);
      pad_in = 32'hFFFF_FFFF; #1;
      chk("R2 partial enable during pulse", 32'hFFFF_0000);
      @(negedge clk);
      pad_in = 32'h0; #1;
      chk("R2 pulse rejected on enabled pins", 32'h0);
      idle(2);
      wr(3'd0, 32'hFFFF_0000);
      // R4 / R8: default glitch mode, table walk
      for (int k = 0; k < 12; k++) begin
         pad_in = {32{GVEC[k][1]}};
         @(negedge clk);
         chk($sformatf("R4 R8 glitch vector %0d", k), {32{GVEC[k][0]}});
      end
      pad_in = 32'h0; idle(3);
      chk("R4 settled low", 32'h0);
      // R5: debounce with divider 1 (tick every 4 slow enables)
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'd1);
      pad_in = 32'hFFFF_FFFF;
      idle(4);
      chk("R5 no change without ticks", 32'h0);
      slow(4);
      chk("R5 one tick not enough", 32'h0);
      slow(3);
      chk("R5 one enable before second tick", 32'h0);
      slow(1);
      chk("R5 second tick takes level", 32'hFFFF_FFFF);
      // R5: short dip between ticks is ignored
      pad_in = 32'h0; slow(2);
      pad_in = 32'hFFFF_FFFF; slow(6);
      chk("R5 dip between ticks ignored", 32'hFFFF_FFFF);
      // R3: disable gives pass-through
      wr(3'd1, 32'hFFFF_FFFF);
      pad_in = 32'h1234_5678; #1;
      chk("R3 disabled pass-through", 32'h1234_5678);
      pad_in = 32'hFFFF_FFFF; idle(1);
      // R7: re-enable, still debounce
      wr(3'd0, 32'hFFFF_FFFF);
      pad_in = 32'h0;
      idle(6);
      chk("R7 mode kept after disable", 32'hFFFF_FFFF);
      // R6: divider masked to field width, counter restarted
      wr(3'd4, 32'hFFFF_C001);
      slow(7);
      chk("R6 masked divider before second tick", 32'hFFFF_FFFF);
      slow(1);
      chk("R6 masked divider second tick", 32'h0);
      // R7: glitch select back on lower half
      wr(3'd2, 32'h0000_FFFF);
      pad_in = 32'hFFFF_FFFF;
      idle(2);
      chk("R7 glitch select on lower half", 32'h0000_FFFF);
      // R8: fresh reset, divider defaults to 0
      pad_in = 32'h0;
      do_reset();
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd0, 32'hFFFF_FFFF);
      pad_in = 32'hFFFF_FFFF;
      slow(3);
      chk("R8 default divider before second tick", 32'h0);
      slow(1);
      chk("R8 default divider second tick", 32'hFFFF_FFFF);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule